// File: doc/BRIEF.md
# Signed-Count Byte Shift and Rotate Unit

This block is the shift/rotate execution unit of a small 8-bit processor datapath. It serves two opcodes: a shift and a rotate. Each takes one signed 4-bit count, and the sign of the count gives the direction. A positive count moves bits toward the most significant end. A negative count moves them toward the least significant end. One opcode therefore covers both directions.

The count comes either from a 4-bit immediate field or from the low four bits of a register operand. These shift and rotate instructions never carry a full 8-bit immediate. The bit that would otherwise choose between a register and a byte immediate becomes a variant bit instead. On the shift opcode it makes a right shift arithmetic. On the rotate opcode it adds the carry flag to the ring as a ninth bit.

The result and the carry-out are registered. They load on a clock edge where the operation enable is high, so a new value is available one cycle after the operation is presented.

Top module: `shrot_unit`

## Requirements
- R1: `cnt_from_reg`=0 takes the count from `imm4`, and `cnt_from_reg`=1 takes it from `cnt_reg`. Either source is read as a two's-complement value from -8 to +7, and the unselected source has no effect on the result.
- R2: A count of zero gives `result` equal to `operand` and `carry_out` equal to `carry_in`, for both opcodes and both values of `mode_alt`.
- R3: On the shift opcode (`op_rot`=0), a positive count n shifts left by n with zeros entering at bit 0, and `carry_out` is operand bit 8-n. `mode_alt` has no effect on a left shift.
- R4: On the shift opcode with `mode_alt`=0, a negative count -n shifts right by n with zeros entering at bit 7, and `carry_out` is operand bit n-1. A count of -8 gives a result of zero and a carry of operand bit 7.
- R5: On the shift opcode with `mode_alt`=1, a negative count -n shifts right with copies of operand bit 7 entering, and `carry_out` is operand bit n-1. A count of -8 gives eight copies of bit 7.
- R6: On the rotate opcode (`op_rot`=1) with `mode_alt`=0, the 8-bit operand rotates by the count modulo 8. `carry_out` is the last bit moved across the end: result bit 0 after a left rotate, result bit 7 after a right rotate. A count of -8 returns the operand unchanged with a carry of operand bit 7.
- R7: On the rotate opcode with `mode_alt`=1, the 9-bit ring {carry_in, operand} rotates by the count modulo 9. `result` is the low 8 bits of the ring and `carry_out` is its top bit.
- R8: `result` and `carry_out` update on the rising edge where `op_en`=1, and they hold their values on any edge where `op_en`=0.
- R9: While `rst_n` is low, `result` is 0 and `carry_out` is 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Operation valid; loads the output registers |
| op_rot | input | 1 | Opcode select: 0 shift, 1 rotate |
| mode_alt | input | 1 | Variant: arithmetic right shift, or rotate through carry |
| cnt_from_reg | input | 1 | Count source: 0 immediate, 1 register |
| imm4 | input | 4 | Signed immediate count |
| cnt_reg | input | 4 | Low bits of the register operand, used as a signed count |
| operand | input | 8 | Data to shift or rotate |
| carry_in | input | 1 | Carry flag in |
| result | output | 8 | Registered result |
| carry_out | output | 1 | Registered carry flag out |

## Verification
The assertions assume that every input is driven to a known value on each clock edge after reset, including the count source that is not selected. They also assume that the count is a 4-bit signed field, so no magnitude above 8 can reach the datapath. The bench drives all inputs at the falling edge and never leaves one undriven. It sweeps all sixteen count codes through both sources, both opcodes and both variants, with several operand and carry patterns. While one source is selected, the other source is loaded with a different code. Every few operations the enable is dropped, so the hold behaviour is exercised between real updates.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic {
    UNIT_SHIFT  = 1'b0,
    UNIT_ROTATE = 1'b1
  } unit_sel_e;
endpackage

// File: rtl/shrot_count_decode.sv
module shrot_count_decode #(
  parameter int CNT_W = 4
) (
  input  logic             from_reg,
  input  logic [CNT_W-1:0] imm_cnt,
  input  logic [CNT_W-1:0] reg_cnt,
  output logic             neg,
  output logic             zero,
  output logic [CNT_W-1:0] mag
);
  logic [CNT_W-1:0] raw;

  always_comb begin
    raw  = from_reg ? reg_cnt : imm_cnt;
    neg  = raw[CNT_W-1];
    zero = (raw == '0);
    // the most negative code maps to 2^(CNT_W-1), which still fits unsigned
    mag  = neg ? (~raw + 1'b1) : raw;
  end
endmodule

// File: rtl/shrot_shift.sv
module shrot_shift #(
  parameter int WIDTH = 8,
  parameter int MAG_W = 4
) (
  input  logic [WIDTH-1:0] operand,
  input  logic             neg,
  input  logic [MAG_W-1:0] mag,
  input  logic             arith,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  logic             fill;
  logic [2*WIDTH-1:0] lft;
  logic [3*WIDTH-1:0] rgt;

  always_comb begin
    fill = arith & operand[WIDTH-1];
    lft  = {{WIDTH{1'b0}}, operand} << mag;
    rgt  = {{WIDTH{fill}}, operand, {WIDTH{1'b0}}} >> mag;
    if (neg) begin
      result    = rgt[2*WIDTH-1:WIDTH];
      carry_out = rgt[WIDTH-1];
    end else begin
      result    = lft[WIDTH-1:0];
      carry_out = lft[WIDTH];
    end
  end
endmodule

// File: rtl/shrot_rotate.sv
module shrot_rotate #(
  parameter int WIDTH = 8,
  parameter int MAG_W = 4
) (
  input  logic [WIDTH-1:0] operand,
  input  logic             neg,
  input  logic [MAG_W-1:0] mag,
  input  logic             thru,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  localparam int RING_W = WIDTH + 1;

  logic [31:0]         mag32;
  logic [MAG_W-1:0]    amt8;
  logic [MAG_W-1:0]    amt9;
  logic [2*WIDTH-1:0]  dbl8;
  logic [2*WIDTH-1:0]  sh8;
  logic [2*RING_W-1:0] dbl9;
  logic [2*RING_W-1:0] sh9;
  logic [WIDTH-1:0]    res8;
  logic [RING_W-1:0]   res9;

  always_comb begin
    mag32 = {{(32-MAG_W){1'b0}}, mag};
    amt8  = MAG_W'(mag32 % WIDTH);
    amt9  = MAG_W'(mag32 % RING_W);
    dbl8  = {operand, operand};
    dbl9  = {carry_in, operand, carry_in, operand};
    if (neg) begin
      sh8  = dbl8 >> amt8;
      res8 = sh8[WIDTH-1:0];
      sh9  = dbl9 >> amt9;
      res9 = sh9[RING_W-1:0];
    end else begin
      sh8  = dbl8 << amt8;
      res8 = sh8[2*WIDTH-1:WIDTH];
      sh9  = dbl9 << amt9;
      res9 = sh9[2*RING_W-1:RING_W];
    end
    if (thru) begin
      result    = res9[WIDTH-1:0];
      carry_out = res9[WIDTH];
    end else begin
      result    = res8;
      carry_out = neg ? res8[WIDTH-1] : res8[0];
    end
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_en,
  input  logic             op_rot,
  input  logic             mode_alt,
  input  logic             cnt_from_reg,
  input  logic [CNT_W-1:0] imm4,
  input  logic [CNT_W-1:0] cnt_reg,
  input  logic [WIDTH-1:0] operand,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  localparam int MAG_W = CNT_W;

  logic             cnt_neg;
  logic             cnt_zero;
  logic [MAG_W-1:0] cnt_mag;
  logic [WIDTH-1:0] sh_res;
  logic             sh_cy;
  logic [WIDTH-1:0] ro_res;
  logic             ro_cy;
  logic [WIDTH-1:0] nxt_result;
  logic             nxt_carry;
  unit_sel_e        unit_sel;

  shrot_count_decode #(.CNT_W(CNT_W)) u_dec (
    .from_reg (cnt_from_reg),
    .imm_cnt  (imm4),
    .reg_cnt  (cnt_reg),
    .neg      (cnt_neg),
    .zero     (cnt_zero),
    .mag      (cnt_mag)
  );

  shrot_shift #(.WIDTH(WIDTH), .MAG_W(MAG_W)) u_shift (
    .operand   (operand),
    .neg       (cnt_neg),
    .mag       (cnt_mag),
    .arith     (mode_alt),
    .result    (sh_res),
    .carry_out (sh_cy)
  );

  shrot_rotate #(.WIDTH(WIDTH), .MAG_W(MAG_W)) u_rot (
    .operand   (operand),
    .neg       (cnt_neg),
    .mag       (cnt_mag),
    .thru      (mode_alt),
    .carry_in  (carry_in),
    .result    (ro_res),
    .carry_out (ro_cy)
  );

  // next-state selection
  always_comb begin
    unit_sel = unit_sel_e'(op_rot);
    if (cnt_zero) begin
      nxt_result = operand;
      nxt_carry  = carry_in;
    end else if (unit_sel == UNIT_ROTATE) begin
      nxt_result = ro_res;
      nxt_carry  = ro_cy;
    end else begin
      nxt_result = sh_res;
      nxt_carry  = sh_cy;
    end
  end

  // output registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      carry_out <= 1'b0;
    end else if (op_en) begin
      result    <= nxt_result;
      carry_out <= nxt_carry;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> ($stable(result) && $stable(carry_out)));

  assert_zero_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && cnt_zero) |=> (result == $past(operand) && carry_out == $past(carry_in)));

  assert_reg_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && cnt_from_reg && cnt_reg == '0) |=> (result == $past(operand)));

  assert_arith_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && !op_rot && mode_alt && cnt_neg) |=> (result[WIDTH-1] == $past(operand[WIDTH-1])));

  assert_rot_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_rot && !mode_alt) |=> ($countones(result) == $countones($past(operand))));

  assert_ring_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_rot && mode_alt) |=>
      ($countones({carry_out, result}) == $countones({$past(carry_in), $past(operand)})));
endmodule

// File: tb/shrot_unit_bench.sv
module shrot_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_en, op_rot, mode_alt, cnt_from_reg, carry_in;
  logic [3:0] imm4, cnt_reg;
  logic [7:0] operand;
  logic [7:0] result;
  logic       carry_out;

  int         checks = 0;
  int         errors = 0;
  logic [7:0] exp_r;
  logic       exp_c;
  string      exp_tag;

  always #5 clk = ~clk;

  shrot_unit u_shrot_unit (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_rot(op_rot), .mode_alt(mode_alt),
    .cnt_from_reg(cnt_from_reg), .imm4(imm4), .cnt_reg(cnt_reg), .operand(operand),
    .carry_in(carry_in), .result(result), .carry_out(carry_out)
  );

  // behavioural reference: one bit step at a time
  function automatic logic [8:0] model(input logic rot, input logic alt,
                                       input logic [3:0] cnt, input logic [7:0] v_in,
                                       input logic c_in);
    logic [7:0] v = v_in;
    logic       c = c_in;
    int n = cnt[3] ? int'(cnt) - 16 : int'(cnt);
    int steps = (n < 0) ? -n : n;
    for (int i = 0; i < steps; i++) begin
      if (!rot) begin
        if (n > 0) begin c = v[7]; v = {v[6:0], 1'b0}; end
        else begin c = v[0]; v = {alt ? v[7] : 1'b0, v[7:1]}; end
      end else if (!alt) begin
        if (n > 0) begin c = v[7]; v = {v[6:0], v[7]}; end
        else begin c = v[0]; v = {v[0], v[7:1]}; end
      end else begin
        if (n > 0) {c, v} = {v, c};
        else {v, c} = {c, v};
      end
    end
    return {c, v};
  endfunction

  function automatic string tag_of(input logic rot, input logic alt, input logic src,
                                   input logic [3:0] cnt);
    if (src) return "R1";
    if (cnt == 4'd0) return "R2";
    if (rot) return alt ? "R7" : "R6";
    if (!cnt[3]) return "R3";
    return alt ? "R5" : "R4";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_r <= 8'h00; exp_c <= 1'b0; exp_tag <= "R9";
    end else if (op_en) begin
      {exp_c, exp_r} <= model(op_rot, mode_alt, cnt_from_reg ? cnt_reg : imm4, operand, carry_in);
      exp_tag <= tag_of(op_rot, mode_alt, cnt_from_reg, cnt_from_reg ? cnt_reg : imm4);
    end else begin
      exp_tag <= "R8";
    end
  end

  task automatic check_now();
    checks++;
    if (result !== exp_r || carry_out !== exp_c) begin
      errors++;
      $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
               exp_tag, result, carry_out, exp_r, exp_c);
    end
  endtask

  task automatic apply(input logic en, input logic rot, input logic alt, input logic src,
                       input logic [3:0] cnt, input logic [7:0] v, input logic c);
    op_en = en; op_rot = rot; mode_alt = alt; cnt_from_reg = src;
    // the unselected source always carries a different code (R1)
    imm4    = src ? ~cnt : cnt;
    cnt_reg = src ? cnt : cnt + 4'd5;
    operand = v; carry_in = c;
    @(negedge clk);
    check_now();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: result=%h carry=%b expected run to finish", result, carry_out);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] pats [4] = '{8'h81, 8'h5A, 8'hF0, 8'h01};
    int k = 0;
    rst_n = 1'b0;
    op_en = 1'b1; op_rot = 1'b0; mode_alt = 1'b0; cnt_from_reg = 1'b0;
    imm4 = 4'd3; cnt_reg = 4'd1; operand = 8'hA5; carry_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_now();  // R9 reset state with enable high
    @(negedge clk);
    check_now();  // R9
    rst_n = 1'b1;
    for (int src = 0; src < 2; src++)
      for (int rot = 0; rot < 2; rot++)
        for (int alt = 0; alt < 2; alt++)
          for (int cnt = 0; cnt < 16; cnt++)
            for (int p = 0; p < 4; p++)
              for (int c = 0; c < 2; c++) begin
                k++;
                // every fifth operation idles with new inputs to exercise R8
                apply((k % 5) != 0, rot[0], alt[0], src[0], cnt[3:0], pats[p] ^ 8'(k), c[0]);
              end
    // corner: counts -8 on every variant (R4 R5 R6 R7)
    apply(1'b1, 1'b0, 1'b0, 1'b0, 4'h8, 8'h96, 1'b0);
    apply(1'b1, 1'b0, 1'b1, 1'b0, 4'h8, 8'h96, 1'b0);
    apply(1'b1, 1'b1, 1'b0, 1'b0, 4'h8, 8'h96, 1'b0);
    apply(1'b1, 1'b1, 1'b1, 1'b0, 4'h8, 8'h96, 1'b1);
    apply(1'b0, 1'b1, 1'b1, 1'b0, 4'h1, 8'h00, 1'b0);  // R8 hold
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule